// File: doc/BRIEF.md
# Gold code sequence generator

This block produces a binary spreading code, one chip per advance, by adding modulo 2 the outputs of two maximal-length shift-register sequences of the same degree m (default m = 10, period 1023 chips). Register A is always restarted from the all-ones state. Register B is restarted from a programmable code-select word. The select word fixes the phase of sequence B against sequence A, so a single generator can emit any of the 2^m−1 members of the code family. The combined code repeats every 2^m−1 chips, although it is not itself a maximal-length sequence.

Software or a sequencer pulses the load input together with a select word to pick a code. It then holds the enable high to stream chips at the clock rate, or lowers it to pause. A one-clock epoch pulse marks the chip that opens each code period.

A small control machine has three states. ST_IDLE is entered on reset and lasts until the first load; the registers do not advance in it. ST_RUN means the last cycle had enable high. ST_HOLD means the last cycle had enable low. The transitions are: IDLE→RUN on load, RUN→HOLD when enable is low without a load, HOLD→RUN when enable is high, and any state→RUN on load.

Top module: `gold_code_gen`

## Requirements
- R1: After synchronous reset chip_o and epoch_o are 0 and the block is in ST_IDLE. Until the first load, en_i has no effect: chip_o stays 0 and epoch_o stays 0.
- R2: A load sets register A to all ones and register B to code_sel_i, with bit i of the select becoming B's stage i. A select of zero is replaced by 1. A load takes priority over en_i in the same cycle, and no advance happens in that cycle.
- R3: Register A, with stage 0 as its output, advances as a(n+10) = a(n+3) XOR a(n). This is the polynomial x^10+x^3+1. Its state is never all zeros.
- R4: Register B, with stage 0 as its output, advances as b(n+10) = b(n+9)^b(n+8)^b(n+6)^b(n+3)^b(n+2)^b(n). This is the polynomial x^10+x^9+x^8+x^6+x^3+x^2+1. Its state is never all zeros.
- R5: chip_o is the XOR of stage 0 of A and stage 0 of B. It changes only after a clock edge at which the registers advance or load.
- R6: After the first load, the registers advance by one chip on each clock edge where en_i is high and load_i is low. With en_i low they hold, and chip_o is unchanged.
- R7: epoch_o is high for exactly one clock after each load, and after each advance that returns A to all ones. With continuous enable these pulses are exactly 2^m−1 = 1023 chips apart.
- R8: Different nonzero select words yield different chip sequences.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Load strobe: restart both registers |
| code_sel_i | input | M | Initial state of register B (family member select) |
| en_i | input | 1 | Advance one chip per clock while high |
| chip_o | output | 1 | Current code chip |
| epoch_o | output | 1 | One-clock pulse at the first chip of a period |

## Verification
Two events can coincide. A load can arrive in the same cycle as an enabled advance, and a load can arrive exactly when that advance would have returned register A to all ones. The bench provokes both: it loads with enable high, and it issues a reload on the 1023rd chip of a running period. In each case it checks that the load wins, that there is no extra advance, and that exactly one epoch pulse appears. Every cycle is judged against a queue-based model of both recurrences, which also measures the spacing between epochs.

// File: rtl/gold_pkg.sv
package gold_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } gen_state_e;

endpackage

// File: rtl/gold_lfsr.sv
module gold_lfsr #(
    parameter int             W       = 10,
    parameter logic [W-1:0]   TAPS    = {{(W-4){1'b0}}, 4'b1001},
    parameter logic [W-1:0]   RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] seed,
    output logic [W-1:0] state_o,
    output logic [W-1:0] next_o,
    output logic         bit_o
);

    logic [W-1:0] q;
    logic [W-1:0] nxt;
    logic [W-1:0] tapped;
    logic         fb;

    assign tapped = q & TAPS;
    assign fb     = ^tapped;

    generate
        for (genvar i = 0; i < W - 1; i++) begin : g_shift
            assign nxt[i] = q[i+1];
        end
    endgenerate
    assign nxt[W-1] = fb;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= RST_VAL;
        end else if (load) begin
            q <= seed;
        end else if (step) begin
            q <= nxt;
        end
    end

    assign state_o = q;
    assign next_o  = nxt;
    assign bit_o   = q[0];

    // R3 R4
    state_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        q != '0);

    // R2
    load_seed_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> q == $past(seed));

    // R6
    hold_state_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !step) |=> $stable(q));

endmodule

// File: rtl/gold_fsm.sv
module gold_fsm (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic                  en,
    output gold_pkg::gen_state_e  state_o,
    output logic                  adv_o
);
    import gold_pkg::*;

    gen_state_e state_q;
    gen_state_e state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (load) begin
            state_d = ST_RUN;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_RUN:  state_d = en ? ST_RUN : ST_HOLD;
                ST_HOLD: state_d = en ? ST_RUN : ST_HOLD;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        adv_o = 1'b0;
        unique case (state_q)
            ST_IDLE: adv_o = 1'b0;
            ST_RUN:  adv_o = en && !load;
            ST_HOLD: adv_o = en && !load;
            default: adv_o = 1'b0;
        endcase
    end

    assign state_o = state_q;

    // R2
    load_to_run_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> state_q == ST_RUN);

    // R1
    idle_stays_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !load) |=> state_q == ST_IDLE);

endmodule

// File: rtl/gold_epoch.sv
module gold_epoch #(
    parameter int M = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic adv,
    input  logic wrap,
    output logic epoch_o
);

    localparam logic [M-1:0] LAST = {{(M-1){1'b1}}, 1'b0};

    logic         ep_q;
    logic [M-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ep_q <= 1'b0;
        end else begin
            ep_q <= load || (adv && wrap);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || load) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    assign epoch_o = ep_q;

    // R7
    period_len_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && !load) |-> (wrap == (cnt_q == LAST)));

    // R7
    epoch_single_chk: assert property (@(posedge clk) disable iff (rst)
        (ep_q && !load) |=> !ep_q);

endmodule

// File: rtl/gold_code_gen.sv
module gold_code_gen #(
    parameter int           M      = 10,
    parameter logic [M-1:0] TAPS_A = 10'h009,
    parameter logic [M-1:0] TAPS_B = 10'h34D
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [M-1:0] code_sel_i,
    input  logic         en_i,
    output logic         chip_o,
    output logic         epoch_o
);
    import gold_pkg::*;

    localparam logic [M-1:0] ONE_VAL = {{(M-1){1'b0}}, 1'b1};

    gen_state_e   state;
    logic         adv;
    logic [M-1:0] seed_b;
    logic [M-1:0] a_state, a_next, b_state, b_next;
    logic         a_bit, b_bit;
    logic         a_wrap;

    assign seed_b = (code_sel_i == '0) ? ONE_VAL : code_sel_i;

    gold_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .load    (load_i),
        .en      (en_i),
        .state_o (state),
        .adv_o   (adv)
    );

    gold_lfsr #(.W(M), .TAPS(TAPS_A), .RST_VAL('1)) u_reg_a (
        .clk     (clk),
        .rst     (rst),
        .load    (load_i),
        .step    (adv),
        .seed    ({M{1'b1}}),
        .state_o (a_state),
        .next_o  (a_next),
        .bit_o   (a_bit)
    );

    gold_lfsr #(.W(M), .TAPS(TAPS_B), .RST_VAL(ONE_VAL)) u_reg_b (
        .clk     (clk),
        .rst     (rst),
        .load    (load_i),
        .step    (adv),
        .seed    (seed_b),
        .state_o (b_state),
        .next_o  (b_next),
        .bit_o   (b_bit)
    );

    assign a_wrap = (a_next == '1);

    gold_epoch #(.M(M)) u_epoch (
        .clk     (clk),
        .rst     (rst),
        .load    (load_i),
        .adv     (adv),
        .wrap    (a_wrap),
        .epoch_o (epoch_o)
    );

    assign chip_o = a_bit ^ b_bit;

    // R2
    zero_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (load_i && code_sel_i == '0) |=> b_state == ONE_VAL);

    // R7
    epoch_at_ones_chk: assert property (@(posedge clk) disable iff (rst)
        epoch_o |-> a_state == '1);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !load_i) |=> (!epoch_o && $stable(chip_o)));

    // R6
    hold_chip_chk: assert property (@(posedge clk) disable iff (rst)
        (!en_i && !load_i) |=> $stable(chip_o));

    // R4
    b_next_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        b_next != '0);

endmodule

// File: tb/sim_gold_code_gen.sv
`timescale 1ns/1ps
module sim_gold_code_gen;

    localparam int M = 10;
    localparam int PER = 1023;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         load_i = 1'b0;
    logic [M-1:0] code_sel_i = '0;
    logic         en_i = 1'b0;
    logic         chip_o;
    logic         epoch_o;

    int total = 0;
    int bad = 0;

    bit ma[$];
    bit mb[$];
    bit m_ep = 1'b0;
    bit m_loaded = 1'b0;
    int since_ep = -1;
    int lcg = 12345;

    always #10 clk = ~clk;

    gold_code_gen #(.M(M)) u0 (
        .clk        (clk),
        .rst        (rst),
        .load_i     (load_i),
        .code_sel_i (code_sel_i),
        .en_i       (en_i),
        .chip_o     (chip_o),
        .epoch_o    (epoch_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        ma.delete(); mb.delete();
        for (int i = 0; i < M; i++) begin
            ma.push_back(1'b1);
            mb.push_back(i == 0);
        end
        m_ep = 1'b0;
        m_loaded = 1'b0;
    endtask

    task automatic model_load(input logic [M-1:0] sel);
        logic [M-1:0] s;
        s = (sel == 0) ? 1 : sel;
        ma.delete(); mb.delete();
        for (int i = 0; i < M; i++) begin
            ma.push_back(1'b1);
            mb.push_back(s[i]);
        end
        m_ep = 1'b1;
        m_loaded = 1'b1;
    endtask

    task automatic model_step();
        bit na, nb, ones;
        na = ma[0] ^ ma[3];
        nb = mb[0] ^ mb[2] ^ mb[3] ^ mb[6] ^ mb[8] ^ mb[9];
        ma.push_back(na); void'(ma.pop_front());
        mb.push_back(nb); void'(mb.pop_front());
        ones = 1'b1;
        foreach (ma[k]) if (!ma[k]) ones = 1'b0;
        m_ep = ones;
    endtask

    task automatic tick(input bit ld, input logic [M-1:0] sel, input bit en, input string tag);
        load_i = ld; code_sel_i = sel; en_i = en;
        @(posedge clk);
        if (ld) model_load(sel);
        else if (m_loaded && en) model_step();
        else m_ep = 1'b0;
        @(negedge clk);
        check({tag, " R5 chip"}, chip_o, ma[0] ^ mb[0]);
        check({tag, " R7 epoch"}, epoch_o, m_ep);
        if (ld) since_ep = 0;
        else if (m_loaded && en) begin
            if (since_ep >= 0) since_ep++;
            if (epoch_o) begin
                check("R7 period", since_ep, PER);
                since_ep = 0;
            end
        end
        load_i = 1'b0;
    endtask

    function automatic bit rnd();
        lcg = lcg * 1103515245 + 12345;
        return lcg[16];
    endfunction

    initial begin
        logic [39:0] seq3, seq5;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 reset chip", chip_o, 0);
        check("R1 reset epoch", epoch_o, 0);
        for (int i = 0; i < 6; i++) tick(1'b0, '0, 1'b1, "R1 idle");
        // R2 zero select, load together with enable
        tick(1'b1, '0, 1'b1, "R2 load");
        // R3 R4 R5 R7: two full periods
        for (int i = 0; i < 2 * PER + 5; i++) tick(1'b0, '0, 1'b1, "R3 R4 run");
        // R6 random enable gaps
        tick(1'b1, 10'h155, 1'b0, "R2 load");
        for (int i = 0; i < 400; i++) tick(1'b0, '0, rnd(), "R6 hold");
        // R8 distinct selects
        tick(1'b1, 10'd3, 1'b1, "R8");
        for (int i = 0; i < 40; i++) begin
            seq3[i] = chip_o;
            tick(1'b0, '0, 1'b1, "R8");
        end
        tick(1'b1, 10'd5, 1'b1, "R8");
        for (int i = 0; i < 40; i++) begin
            seq5[i] = chip_o;
            tick(1'b0, '0, 1'b1, "R8");
        end
        check("R8 codes differ", (seq3 != seq5), 1);
        // R2 R7 reload in the cycle that would wrap
        tick(1'b1, 10'd7, 1'b1, "R2 load");
        for (int i = 0; i < PER - 1; i++) tick(1'b0, '0, 1'b1, "R7 run");
        tick(1'b1, 10'd7, 1'b1, "R2 wrap collision");
        for (int i = 0; i < PER + 3; i++) tick(1'b0, '0, 1'b1, "R7 run");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule